// File: doc/BRIEF.md
# Table-Sequenced 4-bit Processor Core

This core executes one instruction per clock with no program counter increment. Each cycle it does three things. It reads an operation word at the current instruction address. It combines the accumulator with one of sixteen 4-bit data memory words in an arithmetic/logic unit. It then looks up the next instruction address in a jump table.

The jump table is indexed by the current address together with the 4-bit condition code that the ALU produces in the same cycle. Every instruction is therefore an implicit sixteen-way branch. The ALU result is written back either to the accumulator or to the data word that supplied the operand.

The jump table, the operation table and the data memory are internal arrays. They are filled through a write port while a load-enable input holds the core stalled. The current address, the accumulator and the condition code are brought out for observation.

Top module: `cbp_core`

## Requirements
- R1: A synchronous active-high `rst` sets the instruction address (`dbg_addr`) and the accumulator (`dbg_acc`) to 0 at the next rising edge. Reset takes priority over `load_en`.
- R2: In every cycle where `load_en` and `rst` are low, `dbg_addr` takes the jump table entry at index {current address, condition code} at the rising edge. There is no increment.
- R3: The condition code `dbg_cond` is formed from the ALU operands x and y and the 4-bit sum r = x + y:
  - bit 3 is 0 when x + y carries out of 4 bits, and 1 otherwise;
  - bit 2 is 1 when r is 15;
  - bit 1 is 1 when x AND y is nonzero;
  - bit 0 is 1 when x OR y equals 15.
- R4: The opcode selects x and y as follows (a is the accumulator, m is the operand):

  | Opcode | x | y | Result |
  |---|---|---|---|
  | 0 | a | m | a + m |
  | 1 | NOT(a XOR m) | 0 | bitwise equivalence |
  | 2 | a AND m | 15 | (a AND m) − 1 |
  | 3 | a AND m | 0 | a AND m |
  | 4 | a OR m | a | (a OR m) + a |
  | 5 | a OR NOT m | 0 | a OR NOT m |
  | 6 | a | 15 | a − 1 |
  | 7 | a | 0 | a |

  All results are modulo 16.
- R5: The operation word read at the current address has this layout: bits 7:4 are the operand's data memory index, bits 3:1 are the opcode, and bit 0 is the destination flag.
- R6: A destination flag of 0 writes the result to the accumulator and leaves data memory unchanged. A flag of 1 writes the result to the operand's data word and leaves the accumulator unchanged.
- R7: While `load_en` is high, the core is stalled: `dbg_addr`, `dbg_acc` and data memory keep their values, except for writes made through the load port.
- R8: The load port writes `load_data` on a rising edge when both `load_en` and `load_we` are high. The target depends on `load_sel`:
  - `load_sel`=0 writes the jump table at index `load_addr[11:0]`, which is {address, condition};
  - `load_sel`=1 writes the operation table entry for address `load_addr[11:4]`;
  - `load_sel`=2 writes data word `load_addr[3:0]` with `load_data[3:0]`.
- R9: The following load-port writes are ignored and change no table entry:
  - jump or operation table writes with `load_addr[12]`=1;
  - operation table writes whose `load_addr[3:0]` is nonzero;
  - writes with `load_sel`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Stalls the core and opens the load port |
| load_we | input | 1 | Write strobe for the load port |
| load_sel | input | 2 | Load target: 0 jump table, 1 operation table, 2 data memory |
| load_addr | input | 13 | Load index: {reserved, address, condition/low nibble} |
| load_data | input | 8 | Load write data |
| dbg_addr | output | 8 | Current instruction address |
| dbg_acc | output | 4 | Accumulator |
| dbg_cond | output | 4 | Condition code of the current instruction |

## Verification
The hardest thing to observe is a result written to data memory, because memory has no read path to the ports. The bench follows each instruction under test with a fixed add-from-the-same-word instruction. A destination-memory result then appears in the accumulator one cycle later, offset by the known accumulator value. The condition code is made visible the same way. The jump table maps each of the sixteen codes to its own address, so `dbg_addr` after the instruction reveals which branch was taken. Ignored writes are aimed at the exact entries the next instruction uses, during a stall, so any effect would show in that instruction's branch and result.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
   localparam int CC_W  = 4;
   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OP_ADD    = 3'd0,
      OP_EQV    = 3'd1,
      OP_ANDDEC = 3'd2,
      OP_AND    = 3'd3,
      OP_ORADD  = 3'd4,
      OP_ORNOT  = 3'd5,
      OP_DEC    = 3'd6,
      OP_PASS   = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      LD_JUMP = 2'd0,
      LD_OPER = 2'd1,
      LD_DATA = 2'd2,
      LD_NONE = 2'd3
   } ld_sel_e;
endpackage

// File: rtl/cbp_table.sv
module cbp_table #(
   parameter int AW = 4,
   parameter int DW = 4,
   localparam int DEPTH = 1 << AW
)(
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/cbp_alu.sv
module cbp_alu import cbp_pkg::*; #(
   parameter int DATA_W = 4
)(
   input  op_e               op,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] res,
   output logic [CC_W-1:0]   cond
);
   localparam logic [DATA_W-1:0] ONES = '1;

   logic [DATA_W-1:0] x, y, gb, pb;
   logic [DATA_W:0]   cy;

   always_comb begin
      unique case (op)
         OP_ADD:    begin x = acc;             y = opnd; end
         OP_EQV:    begin x = ~(acc ^ opnd);   y = '0;   end
         OP_ANDDEC: begin x = acc & opnd;      y = ONES; end
         OP_AND:    begin x = acc & opnd;      y = '0;   end
         OP_ORADD:  begin x = acc | opnd;      y = acc;  end
         OP_ORNOT:  begin x = acc | ~opnd;     y = '0;   end
         OP_DEC:    begin x = acc;             y = ONES; end
         default:   begin x = acc;             y = '0;   end
      endcase
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign gb[i] = x[i] & y[i];
      assign pb[i] = x[i] | y[i];
   end

   always_comb begin
      cy[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         cy[i+1] = gb[i] | (pb[i] & cy[i]);
      end
   end

   assign res  = x ^ y ^ cy[DATA_W-1:0];
   assign cond = {~cy[DATA_W], &res, |gb, &pb};
endmodule

// File: rtl/cbp_core.sv
module cbp_core import cbp_pkg::*; #(
   parameter int IA_W   = 8,
   parameter int DATA_W = 4,
   parameter int DM_AW  = 4,
   localparam int JT_AW = IA_W + CC_W,
   localparam int LA_W  = JT_AW + 1,
   localparam int OPW   = DM_AW + OPC_W + 1,
   localparam int LD_W  = (IA_W > OPW) ? IA_W : OPW
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              load_en,
   input  logic              load_we,
   input  logic [1:0]        load_sel,
   input  logic [LA_W-1:0]   load_addr,
   input  logic [LD_W-1:0]   load_data,
   output logic [IA_W-1:0]   dbg_addr,
   output logic [DATA_W-1:0] dbg_acc,
   output logic [CC_W-1:0]   dbg_cond
);
   if (DATA_W < 2 || DATA_W > LD_W) begin : g_bad_data_w
      $error("cbp_core: DATA_W must lie in 2..LD_W");
   end
   if (IA_W < 1 || DM_AW < 1) begin : g_bad_aw
      $error("cbp_core: address widths must be positive");
   end

   logic [IA_W-1:0]   cur_addr, nxt_addr;
   logic [DATA_W-1:0] acc_q, opnd, alu_res;
   logic [CC_W-1:0]   cond;
   logic [OPW-1:0]    op_word;
   logic [DM_AW-1:0]  opnd_a;
   op_e               opc;
   logic              op_dest;

   // load-port decode
   logic ld_wr, ld_low, jt_we, ot_we, ld_dm_we, core_dm_we, dm_we;
   logic [DM_AW-1:0]  dm_waddr;
   logic [DATA_W-1:0] dm_wdata;

   assign ld_wr    = load_en & load_we;
   assign ld_low   = ~load_addr[LA_W-1];
   assign jt_we    = ld_wr & ld_low & (ld_sel_e'(load_sel) == LD_JUMP);
   assign ot_we    = ld_wr & ld_low & (ld_sel_e'(load_sel) == LD_OPER)
                   & (load_addr[CC_W-1:0] == '0);
   assign ld_dm_we = ld_wr & (ld_sel_e'(load_sel) == LD_DATA);

   assign core_dm_we = ~rst & ~load_en & op_dest;
   assign dm_we      = ld_dm_we | core_dm_we;
   assign dm_waddr   = load_en ? load_addr[DM_AW-1:0]  : opnd_a;
   assign dm_wdata   = load_en ? load_data[DATA_W-1:0] : alu_res;

   cbp_table #(.AW(JT_AW), .DW(IA_W)) u_jump (
      .clk   (clk),
      .we    (jt_we),
      .waddr (load_addr[JT_AW-1:0]),
      .wdata (load_data[IA_W-1:0]),
      .raddr ({cur_addr, cond}),
      .rdata (nxt_addr)
   );

   cbp_table #(.AW(IA_W), .DW(OPW)) u_oper (
      .clk   (clk),
      .we    (ot_we),
      .waddr (load_addr[JT_AW-1:CC_W]),
      .wdata (load_data[OPW-1:0]),
      .raddr (cur_addr),
      .rdata (op_word)
   );

   assign opnd_a  = op_word[OPW-1:OPC_W+1];
   assign opc     = op_e'(op_word[OPC_W:1]);
   assign op_dest = op_word[0];

   cbp_table #(.AW(DM_AW), .DW(DATA_W)) u_data (
      .clk   (clk),
      .we    (dm_we),
      .waddr (dm_waddr),
      .wdata (dm_wdata),
      .raddr (opnd_a),
      .rdata (opnd)
   );

   cbp_alu #(.DATA_W(DATA_W)) u_alu (
      .op   (opc),
      .acc  (acc_q),
      .opnd (opnd),
      .res  (alu_res),
      .cond (cond)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_addr <= '0;
         acc_q    <= '0;
      end else if (!load_en) begin
         cur_addr <= nxt_addr;
         if (!op_dest) acc_q <= alu_res;
      end
   end

   assign dbg_addr = cur_addr;
   assign dbg_acc  = acc_q;
   assign dbg_cond = cond;
endmodule

// File: rtl/cbp_core_chk.sv
module cbp_core_chk #(
   parameter int IA_W   = 8,
   parameter int DATA_W = 4
)(
   input logic              clk,
   input logic              rst,
   input logic              load_en,
   input logic              op_dest,
   input logic [IA_W-1:0]   nxt_addr,
   input logic [DATA_W-1:0] alu_res,
   input logic [IA_W-1:0]   dbg_addr,
   input logic [DATA_W-1:0] dbg_acc,
   input logic [3:0]        dbg_cond
);
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (dbg_addr == '0 && dbg_acc == '0));

   a_r2_next_from_table: assert property (@(posedge clk) disable iff (rst)
      !load_en |=> dbg_addr == $past(nxt_addr));

   a_r3_carry_needs_generate: assert property (@(posedge clk) disable iff (rst)
      !dbg_cond[3] |-> dbg_cond[1]);

   a_r6_acc_takes_result: assert property (@(posedge clk) disable iff (rst)
      (!load_en && !op_dest) |=> dbg_acc == $past(alu_res));

   a_r6_mem_dest_keeps_acc: assert property (@(posedge clk) disable iff (rst)
      (!load_en && op_dest) |=> $stable(dbg_acc));

   a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
      load_en |=> ($stable(dbg_addr) && $stable(dbg_acc)));
endmodule

bind cbp_core cbp_core_chk #(.IA_W(IA_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .load_en  (load_en),
   .op_dest  (op_dest),
   .nxt_addr (nxt_addr),
   .alu_res  (alu_res),
   .dbg_addr (dbg_addr),
   .dbg_acc  (dbg_acc),
   .dbg_cond (dbg_cond)
);

// File: tb/cbp_core_bench.sv
module cbp_core_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load_en = 1'b1;
   logic        load_we = 1'b0;
   logic [1:0]  load_sel = 2'd3;
   logic [12:0] load_addr = '0;
   logic [7:0]  load_data = '0;
   logic [7:0]  dbg_addr;
   logic [3:0]  dbg_acc;
   logic [3:0]  dbg_cond;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   cbp_core u_cbp_core (
      .clk(clk), .rst(rst), .load_en(load_en), .load_we(load_we),
      .load_sel(load_sel), .load_addr(load_addr), .load_data(load_data),
      .dbg_addr(dbg_addr), .dbg_acc(dbg_acc), .dbg_cond(dbg_cond)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // returns {cond, result} computed from R3 and R4
   function automatic logic [7:0] model(input logic [3:0] a, input logic [3:0] m,
                                        input logic [2:0] op);
      int x, y, s;
      logic [3:0] r, cc;
      case (op)
         3'd0: begin x = a;               y = m;  end
         3'd1: begin x = 15 - (a ^ m);    y = 0;  end
         3'd2: begin x = a & m;           y = 15; end
         3'd3: begin x = a & m;           y = 0;  end
         3'd4: begin x = a | m;           y = a;  end
         3'd5: begin x = (a | (15 - m));  y = 0;  end
         3'd6: begin x = a;               y = 15; end
         default: begin x = a;            y = 0;  end
      endcase
      s  = x + y;
      r  = 4'(s % 16);
      cc = {(s < 16), (r == 4'd15), ((x & y) != 0), ((x | y) == 15)};
      return {cc, r};
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [12:0] a, input logic [7:0] d);
      load_en = 1'b1; load_we = 1'b1; load_sel = sel; load_addr = a; load_data = d;
      step();
      load_we = 1'b0;
   endtask

   // fixed program: addr 0 loads acc from word 0, addr 1 is under test,
   // addr 1 branches to 0x20|cond, each 0x2c adds word 1 into acc (R8)
   task automatic fill_base();
      wr(2'd1, 13'h0000, 8'h00);
      for (int c = 0; c < 16; c++) begin
         wr(2'd0, {1'b0, 8'h00, 4'(c)}, 8'h01);
         wr(2'd0, {1'b0, 8'h01, 4'(c)}, 8'h20 | 8'(c));
         wr(2'd1, {1'b0, 8'h20 | 8'(c), 4'h0}, 8'h10);
      end
   endtask

   task automatic run_case(input logic [3:0] a, input logic [3:0] m,
                           input logic [2:0] op, input logic dst);
      logic [7:0] e;
      e = model(a, m, op);
      wr(2'd2, 13'h0000, {4'h0, a});
      wr(2'd2, 13'h0001, {4'h0, m});
      wr(2'd1, {1'b0, 8'h01, 4'h0}, {4'h1, op, dst});
      load_en = 1'b0; rst = 1'b1;
      step();
      rst = 1'b0;
      check("R1 addr after reset", dbg_addr, 8'h00);
      check("R1 acc after reset", dbg_acc, 4'h0);
      step();
      check("R5 acc loaded from word 0", dbg_acc, a);
      check("R3 condition code", dbg_cond, e[7:4]);
      step();
      check("R2 branch on condition", dbg_addr, 8'h20 | 8'(e[7:4]));
      if (!dst) check("R4 R6 result to acc", dbg_acc, e[3:0]);
      else      check("R6 acc kept on memory dest", dbg_acc, a);
      step();
      if (!dst) check("R6 memory untouched", dbg_acc, 4'(e[3:0] + m));
      else      check("R6 memory holds result", dbg_acc, 4'(a + e[3:0]));
      load_en = 1'b1;
   endtask

   task automatic stall_case();
      logic [7:0] e;
      e = model(4'd5, 4'd6, 3'd0);
      wr(2'd2, 13'h0000, 8'h05);
      wr(2'd2, 13'h0001, 8'h06);
      wr(2'd1, {1'b0, 8'h01, 4'h0}, 8'h10);
      load_en = 1'b0; rst = 1'b1;
      step();
      rst = 1'b0;
      step();
      load_en = 1'b1;
      step(); step(); step();
      check("R7 addr held in stall", dbg_addr, 8'h01);
      check("R7 acc held in stall", dbg_acc, 4'h5);
      wr(2'd1, {1'b0, 8'h01, 4'h5}, 8'h1D);
      wr(2'd0, {1'b1, 8'h01, e[7:4]}, 8'hFF);
      wr(2'd3, 13'h0001, 8'h0F);
      check("R7 addr held during loads", dbg_addr, 8'h01);
      load_en = 1'b0;
      step();
      check("R9 jump entry unchanged", dbg_addr, 8'h20 | 8'(e[7:4]));
      check("R9 op entry unchanged", dbg_acc, e[3:0]);
      step();
      check("R9 data word unchanged", dbg_acc, 4'(e[3:0] + 4'd6));
      load_en = 1'b1;
   endtask

   initial begin
      @(negedge clk);
      step();
      check("R1 reset state addr", dbg_addr, 8'h00);
      check("R1 reset state acc", dbg_acc, 4'h0);
      fill_base();
      run_case(4'd9,  4'd8,  3'd0, 1'b0);
      run_case(4'd3,  4'd12, 3'd0, 1'b1);
      run_case(4'd6,  4'd6,  3'd1, 1'b0);
      run_case(4'd10, 4'd5,  3'd1, 1'b1);
      run_case(4'd12, 4'd10, 3'd2, 1'b0);
      run_case(4'd3,  4'd4,  3'd2, 1'b1);
      run_case(4'd15, 4'd7,  3'd3, 1'b0);
      run_case(4'd11, 4'd13, 3'd4, 1'b0);
      run_case(4'd9,  4'd6,  3'd4, 1'b1);
      run_case(4'd2,  4'd9,  3'd5, 1'b0);
      run_case(4'd0,  4'd15, 3'd5, 1'b1);
      run_case(4'd0,  4'd0,  3'd6, 1'b0);
      run_case(4'd7,  4'd1,  3'd6, 1'b1);
      run_case(4'd13, 4'd2,  3'd7, 1'b0);
      run_case(4'd4,  4'd11, 3'd7, 1'b1);
      stall_case();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule